// File: doc/BRIEF.md
# DTMF Tone Pair Synthesizer

This block turns a 4-bit key code into a dual-tone multi-frequency signal as digital samples. It runs from a 3.579545 MHz reference clock. Each code selects one low-group tone and one high-group tone.

Each tone has its own integer divider. A divider steps an index through a 32-entry sine table, and the divide ratio is picked at run time from the key code. The block puts out the two tone streams separately and also their sum. In the sum, the high-group tone is raised by 5/4, about 2 dB, and the result is saturated to the DAC width.

Tone output can run in one of two ways. It can play for as long as the transmitter is enabled. It can also be sent as a single counted burst: a timed tone followed by a timed pause. The end of that pause raises an interrupt request.

Top module: `dtmf_synth`

## Requirements
- R1: While reset is held, and right after it, `dac_o`, `row_sample_o` and `col_sample_o` are 0, and `tone_active_o` and `irq_o` are low.
- R2: The key code selects a low-group index (0..3 = 697, 770, 852, 941 Hz) and a high-group index (0..3 = 1209, 1336, 1477, 1633 Hz) as follows.
  - Codes 1, 2, 3 and 13 use low index 0. Codes 4, 5, 6 and 14 use low index 1. Codes 7, 8, 9 and 15 use low index 2. Codes 11, 10, 12 and 0 use low index 3.
  - Codes 1, 4, 7 and 11 use high index 0. Codes 2, 5, 8 and 10 use high index 1. Codes 3, 6, 9 and 12 use high index 2. Codes 13, 14, 15 and 0 use high index 3.
- R3: Each tone's divide ratio is N = floor((CLK_HZ + 16*f) / (32*f)). With the default clock this gives 160, 145, 131 and 119 for the low group and 93, 84, 76 and 69 for the high group. A full period of the sample stream is 32*N clock cycles.
- R4: Each stream walks a 32-entry sine table with peak 400, holding each entry for N cycles.
  - A write restarts both streams at entry 0, whose value is 0.
  - Entry 1 has the value 78.
  - The stream crosses from negative to zero once per period.
- R5: `dac_o` equals row + col + (col >>> 2), where >>> is an arithmetic shift that rounds toward minus infinity. The result is saturated to [-2^(DAC_W-1), 2^(DAC_W-1)-1], which is [-512, 511] by default.
- R6: The tone plays only while `tone_active_o` is high. While it is low, all three sample outputs are 0.
  - With burst mode off, the tone is active whenever `tx_en_i` is high and a code has been written since reset. It does not play before the first write.
- R7: A write with `burst_en_i` high and `tx_en_i` high plays one burst. The tone is on for BURST_TICKS cycles, then off for BURST_TICKS cycles, then stays off until the next write.
  - BURST_TICKS defaults to CLK_HZ*51/1000.
- R8: The clock edge that ends the burst pause sets `irq_o`. `irq_o` is cleared one cycle after `irq_clr_i` or after any write.
- R9: When `tx_en_i` is low, `tone_active_o` is low at the next edge and any burst in progress is abandoned. The latched code is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, 3.579545 MHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the key code, one cycle |
| code_i | input | 4 | Key code |
| tx_en_i | input | 1 | Transmitter enable |
| burst_en_i | input | 1 | Burst mode select, sampled on a write |
| irq_clr_i | input | 1 | Clears the interrupt request |
| row_sample_o | output | SAMPLE_W | Low-group sample, signed |
| col_sample_o | output | SAMPLE_W | High-group sample, signed |
| dac_o | output | DAC_W | Mixed and saturated sample, signed |
| tone_active_o | output | 1 | High while a tone is sounding |
| irq_o | output | 1 | Burst-complete interrupt request |

## Verification
The properties assume that all control inputs change only between clock edges and that `wr_en_i` is a pulse one cycle long. The bench drives every input on the falling edge and drops each write strobe after a single cycle. The property that a tone always starts from a zero sample holds only when `tx_en_i` is high during the write, and the bench only writes an audible code under that condition. Frequencies are checked by timing successive negative-to-zero crossings of each stream against periods that the bench computes itself from the nominal tone frequencies.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

  localparam int unsigned LUT_DEPTH = 32;
  localparam int unsigned IDX_W     = $clog2(LUT_DEPTH);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PLAY,
    ST_BURST_ON,
    ST_BURST_GAP
  } tx_state_e;

  function automatic int unsigned row_hz(input int unsigned sel);
    case (sel)
      0:       return 697;
      1:       return 770;
      2:       return 852;
      default: return 941;
    endcase
  endfunction

  function automatic int unsigned col_hz(input int unsigned sel);
    case (sel)
      0:       return 1209;
      1:       return 1336;
      2:       return 1477;
      default: return 1633;
    endcase
  endfunction

  // nearest integer ratio so that LUT_DEPTH entries per period match f
  function automatic int unsigned div_ratio(input int unsigned clk_hz, input int unsigned f);
    return (clk_hz + (LUT_DEPTH / 2) * f) / (LUT_DEPTH * f);
  endfunction

  function automatic logic [1:0] code_row(input logic [3:0] code);
    case (code)
      4'd1, 4'd2, 4'd3, 4'd13:  return 2'd0;
      4'd4, 4'd5, 4'd6, 4'd14:  return 2'd1;
      4'd7, 4'd8, 4'd9, 4'd15:  return 2'd2;
      default:                  return 2'd3;
    endcase
  endfunction

  function automatic logic [1:0] code_col(input logic [3:0] code);
    case (code)
      4'd1, 4'd4, 4'd7, 4'd11:  return 2'd0;
      4'd2, 4'd5, 4'd8, 4'd10:  return 2'd1;
      4'd3, 4'd6, 4'd9, 4'd12:  return 2'd2;
      default:                  return 2'd3;
    endcase
  endfunction

  // quarter wave of 400*sin(2*pi*k/32), k = 0..8
  function automatic logic [8:0] sine_quarter(input logic [3:0] k);
    case (k)
      4'd0:    return 9'd0;
      4'd1:    return 9'd78;
      4'd2:    return 9'd153;
      4'd3:    return 9'd222;
      4'd4:    return 9'd283;
      4'd5:    return 9'd333;
      4'd6:    return 9'd370;
      4'd7:    return 9'd392;
      default: return 9'd400;
    endcase
  endfunction

endpackage

// File: rtl/dtmf_tone_gen.sv
module dtmf_tone_gen
  import dtmf_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 3579545,
  parameter bit          HIGH_GROUP = 1'b0,
  parameter int unsigned SAMPLE_W   = 10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic [1:0]                 sel_i,
  output logic signed [SAMPLE_W-1:0] sample_o
);

  // lowest tone of the group needs the largest ratio
  localparam int unsigned MAX_DIV =
    div_ratio(CLK_HZ, HIGH_GROUP ? col_hz(0) : row_hz(0));
  localparam int unsigned CNT_W = $clog2(MAX_DIV + 1);

  logic [CNT_W-1:0] ratio_tab [4];
  logic [CNT_W-1:0] cnt_q, last_cnt;
  logic [IDX_W-1:0] idx_q;

  for (genvar g = 0; g < 4; g++) begin : g_ratio
    if (HIGH_GROUP) begin : g_hi
      assign ratio_tab[g] = CNT_W'(div_ratio(CLK_HZ, col_hz(g)));
    end else begin : g_lo
      assign ratio_tab[g] = CNT_W'(div_ratio(CLK_HZ, row_hz(g)));
    end
  end

  assign last_cnt = ratio_tab[sel_i] - CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (cnt_q == last_cnt) begin
      cnt_q <= '0;
      idx_q <= idx_q + IDX_W'(1);
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // quadrant folding of the quarter table
  logic [1:0]                 quad;
  logic [2:0]                 pos;
  logic [3:0]                 mag_idx;
  logic signed [SAMPLE_W-1:0] mag;

  assign quad    = idx_q[IDX_W-1 -: 2];
  assign pos     = idx_q[2:0];
  assign mag_idx = quad[0] ? (4'd8 - {1'b0, pos}) : {1'b0, pos};
  assign mag     = SAMPLE_W'(sine_quarter(mag_idx));
  assign sample_o = quad[1] ? -mag : mag;

endmodule

// File: rtl/dtmf_mixer.sv
module dtmf_mixer #(
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned DAC_W    = 10
) (
  input  logic signed [SAMPLE_W-1:0] row_i,
  input  logic signed [SAMPLE_W-1:0] col_i,
  output logic signed [DAC_W-1:0]    dac_o
);

  localparam int unsigned SUM_W = ((SAMPLE_W > DAC_W) ? SAMPLE_W : DAC_W) + 3;
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((1 << (DAC_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - SUM_W'(1);

  logic signed [SUM_W-1:0] row_ext, col_ext, sum;

  assign row_ext = SUM_W'(row_i);
  assign col_ext = SUM_W'(col_i);
  // col * 5/4 is about +2 dB
  assign sum     = row_ext + col_ext + (col_ext >>> 2);

  always_comb begin
    if (sum > SAT_HI)      dac_o = DAC_W'(SAT_HI);
    else if (sum < SAT_LO) dac_o = DAC_W'(SAT_LO);
    else                   dac_o = DAC_W'(sum);
  end

endmodule

// File: rtl/dtmf_burst_ctl.sv
module dtmf_burst_ctl
  import dtmf_pkg::*;
#(
  parameter int unsigned BURST_TICKS = 182556
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic burst_en_i,
  input  logic tx_en_i,
  input  logic loaded_i,
  input  logic irq_clr_i,
  output logic active_o,
  output logic active_d_o,
  output logic irq_o
);

  localparam int unsigned BW = $clog2(BURST_TICKS + 1);
  localparam logic [BW-1:0] LOAD = BW'(BURST_TICKS - 1);

  tx_state_e   state_q, state_d;
  logic [BW-1:0] cnt_q, cnt_d;
  logic        irq_q, irq_d;
  logic        burst_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    irq_d   = irq_q & ~irq_clr_i;
    if (wr_en_i) irq_d = 1'b0;
    if (!tx_en_i) begin
      state_d = ST_IDLE;
    end else if (wr_en_i) begin
      state_d = burst_en_i ? ST_BURST_ON : ST_PLAY;
      cnt_d   = LOAD;
    end else begin
      unique case (state_q)
        ST_IDLE: if (loaded_i && !burst_q) state_d = ST_PLAY;
        ST_PLAY: state_d = ST_PLAY;
        ST_BURST_ON: begin
          if (cnt_q == '0) begin
            state_d = ST_BURST_GAP;
            cnt_d   = LOAD;
          end else begin
            cnt_d = cnt_q - BW'(1);
          end
        end
        ST_BURST_GAP: begin
          if (cnt_q == '0) begin
            state_d = ST_IDLE;
            irq_d   = 1'b1;
          end else begin
            cnt_d = cnt_q - BW'(1);
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      irq_q   <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      irq_q   <= irq_d;
      if (wr_en_i) burst_q <= burst_en_i;
    end
  end

  assign active_o   = (state_q == ST_PLAY) || (state_q == ST_BURST_ON);
  assign active_d_o = (state_d == ST_PLAY) || (state_d == ST_BURST_ON);
  assign irq_o      = irq_q;

endmodule

// File: rtl/dtmf_synth.sv
module dtmf_synth
  import dtmf_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 3579545,
  parameter int unsigned SAMPLE_W    = 10,
  parameter int unsigned DAC_W       = 10,
  parameter int unsigned BURST_MS    = 51,
  parameter int unsigned BURST_TICKS = (CLK_HZ * BURST_MS) / 1000
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [3:0]                 code_i,
  input  logic                       tx_en_i,
  input  logic                       burst_en_i,
  input  logic                       irq_clr_i,
  output logic signed [SAMPLE_W-1:0] row_sample_o,
  output logic signed [SAMPLE_W-1:0] col_sample_o,
  output logic signed [DAC_W-1:0]    dac_o,
  output logic                       tone_active_o,
  output logic                       irq_o
);

  logic [3:0] code_q;
  logic       loaded_q;
  logic       active_q, active_d, gen_clear;
  logic [1:0] row_sel, col_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q   <= '0;
      loaded_q <= 1'b0;
    end else if (wr_en_i) begin
      code_q   <= code_i;
      loaded_q <= 1'b1;
    end
  end

  assign row_sel = code_row(code_q);
  assign col_sel = code_col(code_q);

  dtmf_burst_ctl #(
    .BURST_TICKS(BURST_TICKS)
  ) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .burst_en_i (burst_en_i),
    .tx_en_i    (tx_en_i),
    .loaded_i   (loaded_q),
    .irq_clr_i  (irq_clr_i),
    .active_o   (active_q),
    .active_d_o (active_d),
    .irq_o      (irq_o)
  );

  // hold phase at zero unless sounding; restart on write, start and stop
  assign gen_clear = wr_en_i || !active_q || !active_d;

  dtmf_tone_gen #(
    .CLK_HZ(CLK_HZ), .HIGH_GROUP(1'b0), .SAMPLE_W(SAMPLE_W)
  ) u_row (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (gen_clear),
    .sel_i    (row_sel),
    .sample_o (row_sample_o)
  );

  dtmf_tone_gen #(
    .CLK_HZ(CLK_HZ), .HIGH_GROUP(1'b1), .SAMPLE_W(SAMPLE_W)
  ) u_col (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (gen_clear),
    .sel_i    (col_sel),
    .sample_o (col_sample_o)
  );

  dtmf_mixer #(
    .SAMPLE_W(SAMPLE_W), .DAC_W(DAC_W)
  ) u_mix (
    .row_i (row_sample_o),
    .col_i (col_sample_o),
    .dac_o (dac_o)
  );

  assign tone_active_o = active_q;

endmodule

// File: rtl/dtmf_synth_chk.sv
module dtmf_synth_chk #(
  parameter int unsigned SAMPLE_W = 10,
  parameter int unsigned DAC_W    = 10
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_en_i,
  input logic                       tx_en_i,
  input logic                       irq_clr_i,
  input logic signed [SAMPLE_W-1:0] row_sample_o,
  input logic signed [SAMPLE_W-1:0] col_sample_o,
  input logic signed [DAC_W-1:0]    dac_o,
  input logic                       tone_active_o,
  input logic                       irq_o
);

  a_r9_tx_off_silences: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> !tone_active_o);

  a_r8_write_clears_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !irq_o);

  a_r8_clr_clears_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !tone_active_o && irq_o) |=> !irq_o);

  a_r6_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tone_active_o |-> (dac_o == '0 && row_sample_o == '0 && col_sample_o == '0));

  a_r7_irq_after_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (!tone_active_o && !$past(tone_active_o)));

  a_r4_write_starts_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && tx_en_i) |=> (tone_active_o && row_sample_o == '0 && col_sample_o == '0));

endmodule

bind dtmf_synth dtmf_synth_chk #(.SAMPLE_W(SAMPLE_W), .DAC_W(DAC_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .tx_en_i       (tx_en_i),
  .irq_clr_i     (irq_clr_i),
  .row_sample_o  (row_sample_o),
  .col_sample_o  (col_sample_o),
  .dac_o         (dac_o),
  .tone_active_o (tone_active_o),
  .irq_o         (irq_o)
);

// File: tb/tb_dtmf_synth.sv
module tb_dtmf_synth;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 3579545;
  localparam int BT         = 2000;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, tx_en = 1'b0, burst_en = 1'b0, irq_clr = 1'b0;
  logic [3:0] code = '0;
  logic signed [9:0] row_s, col_s, dac;
  logic active, irq;

  int n_checks = 0, n_errors = 0;
  int cyc = 0;
  int exp_row[$], exp_col[$];
  int row_peak = 0, col_peak = 0, dac_max = 0, dac_min = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dtmf_synth #(.CLK_HZ(CLK_HZ), .BURST_TICKS(BT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .code_i(code),
    .tx_en_i(tx_en), .burst_en_i(burst_en), .irq_clr_i(irq_clr),
    .row_sample_o(row_s), .col_sample_o(col_s), .dac_o(dac),
    .tone_active_o(active), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lo_hz(input int c);
    int hz [4] = '{697, 770, 852, 941};
    int r;
    if (c inside {1, 2, 3, 13}) r = 0;
    else if (c inside {4, 5, 6, 14}) r = 1;
    else if (c inside {7, 8, 9, 15}) r = 2;
    else r = 3;
    return hz[r];
  endfunction

  function automatic int hi_hz(input int c);
    int hz [4] = '{1209, 1336, 1477, 1633};
    int k;
    if (c inside {1, 4, 7, 11}) k = 0;
    else if (c inside {2, 5, 8, 10}) k = 1;
    else if (c inside {3, 6, 9, 12}) k = 2;
    else k = 3;
    return hz[k];
  endfunction

  function automatic int period_of(input int f);
    longint n;
    n = (longint'(CLK_HZ) + 16 * f) / (32 * f);
    return int'(32 * n);
  endfunction

  // R5 mix monitor, every cycle
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        int e;
        e = int'(row_s) + int'(col_s) + (int'(col_s) >>> 2);
        if (e > 511) e = 511;
        if (e < -512) e = -512;
        check(int'(dac) == e, "R5 mix", int'(dac), e);
        if (int'(dac) > dac_max) dac_max = int'(dac);
        if (int'(dac) < dac_min) dac_min = int'(dac);
      end
    end
  end

  // R3/R4 row period monitor
  initial begin
    int prev = 0, t0 = 0;
    bit have = 0;
    forever begin
      @(negedge clk);
      if (exp_row.size() > 0) begin
        if (int'(row_s) > row_peak) row_peak = int'(row_s);
        if (prev < 0 && int'(row_s) >= 0) begin
          if (!have) begin t0 = cyc; have = 1; end
          else begin
            check(cyc - t0 == exp_row[0], "R3 row period", cyc - t0, exp_row[0]);
            check(row_peak == 400, "R4 row peak", row_peak, 400);
            void'(exp_row.pop_front());
            have = 0;
          end
        end
      end else begin
        have = 0;
        row_peak = 0;
      end
      prev = int'(row_s);
    end
  end

  // R3/R4 column period monitor
  initial begin
    int prev = 0, t0 = 0;
    bit have = 0;
    forever begin
      @(negedge clk);
      if (exp_col.size() > 0) begin
        if (int'(col_s) > col_peak) col_peak = int'(col_s);
        if (prev < 0 && int'(col_s) >= 0) begin
          if (!have) begin t0 = cyc; have = 1; end
          else begin
            check(cyc - t0 == exp_col[0], "R3 col period", cyc - t0, exp_col[0]);
            check(col_peak == 400, "R4 col peak", col_peak, 400);
            void'(exp_col.pop_front());
            have = 0;
          end
        end
      end else begin
        have = 0;
        col_peak = 0;
      end
      prev = int'(col_s);
    end
  end

  task automatic write_code(input int c, input bit burst);
    @(negedge clk);
    wr_en = 1'b1; code = 4'(c); burst_en = burst;
    @(negedge clk);
    wr_en = 1'b0; burst_en = 1'b0;
  endtask

  // R2 driver: push expected periods, wait for the monitors
  task automatic play_and_measure(input int c);
    write_code(c, 1'b0);
    repeat (3) @(negedge clk);
    exp_row.push_back(period_of(lo_hz(c)));
    exp_col.push_back(period_of(hi_hz(c)));
    while (exp_row.size() > 0 || exp_col.size() > 0) @(negedge clk);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    n_errors++;
    n_checks++;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    int cnt;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(dac == 0 && row_s == 0 && col_s == 0, "R1 samples in reset", int'(dac), 0);
    check(!active && !irq, "R1 flags in reset", int'(active) + int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!active && !irq && dac == 0, "R1 after reset", int'(active), 0);

    // R6 no tone before first write
    tx_en = 1'b1;
    repeat (20) @(negedge clk);
    check(!active, "R6 silent before write", int'(active), 0);
    check(dac == 0, "R6 dac before write", int'(dac), 0);

    // R4 sequence start
    write_code(1, 1'b0);
    check(active, "R6 active after write", int'(active), 1);
    check(row_s == 0 && col_s == 0, "R4 starts at zero", int'(row_s) + int'(col_s), 0);
    repeat (93) @(negedge clk);
    check(int'(col_s) == 78, "R4 col entry1 after 93", int'(col_s), 78);
    repeat (67) @(negedge clk);
    check(int'(row_s) == 78, "R4 row entry1 after 160", int'(row_s), 78);

    // R2/R3 frequency per code, covering every row and column
    play_and_measure(1);
    play_and_measure(5);
    play_and_measure(9);
    play_and_measure(0);
    play_and_measure(12);
    play_and_measure(13);
    play_and_measure(11);
    check(dac_max == 511, "R5 positive saturation", dac_max, 511);
    check(dac_min == -512, "R5 negative saturation", dac_min, -512);

    // R9 transmitter off, R6 resume with held code
    @(negedge clk); tx_en = 1'b0;
    @(negedge clk);
    check(!active && dac == 0, "R9 tx off silences", int'(active), 0);
    repeat (10) @(negedge clk);
    tx_en = 1'b1;
    @(negedge clk);
    check(active, "R6 resumes with held code", int'(active), 1);

    // R7 burst timing, R8 interrupt
    write_code(5, 1'b1);
    cnt = 0;
    while (active && cnt < 3 * BT) begin cnt++; @(negedge clk); end
    check(cnt == BT, "R7 burst on length", cnt, BT);
    cnt = 0;
    while (!irq && cnt < 3 * BT) begin cnt++; @(negedge clk); end
    check(cnt == BT, "R7 burst gap length", cnt, BT);
    check(irq, "R8 irq after burst", int'(irq), 1);
    repeat (100) @(negedge clk);
    check(!active, "R7 single burst only", int'(active), 0);
    irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    check(!irq, "R8 irq_clr clears", int'(irq), 0);

    // R9 abort burst
    write_code(9, 1'b1);
    repeat (50) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    check(!active, "R9 burst aborted", int'(active), 0);
    tx_en = 1'b1;
    repeat (3 * BT) @(negedge clk);
    check(!irq && !active, "R9 aborted burst no irq", int'(irq) + int'(active), 0);

    // R8 write clears irq
    write_code(3, 1'b1);
    while (!irq) @(negedge clk);
    write_code(1, 1'b0);
    check(!irq, "R8 write clears irq", int'(irq), 0);
    check(active, "R6 continuous after write", int'(active), 1);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule